// File: doc/BRIEF.md
# Single-Phase Enhanced PLL with Windowed Loop Filters

This block tracks the fundamental of a single-phase sampled voltage. It takes one signed sample for each strobe and keeps three state estimates: the amplitude, the phase angle and the angular frequency. From the phase and amplitude it rebuilds the fundamental as A·sin θ. The difference between the input and that rebuilt wave drives two loops. The amplitude loop integrates the error times sin θ. The frequency loop runs the error times cos θ through a proportional-integral controller, and the result offsets the nominal phase step.

Both loop products pass through a running-sum averager before they reach the integrators. The averager spans one period of the lowest ripple frequency: 100 samples at 10 kHz, which is 10 ms. It therefore nulls every multiple of 100 Hz and passes DC. Odd input harmonics and step changes of the fundamental put their ripple at those multiples, so the loop state stays smooth. The frequency estimate leaves the block as a phase increment per sample, so a front-end delay line can follow it.

Top module: `epll_mwf`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `fund_out`=0, `amp_out`=0, `phase_out`=0 and `freq_inc_out`=21474836. That value is 50 Hz at 10 kHz in phase units, where 2^32 is one full turn.
- R2: Sine is a half-wave rational approximation 32767·16·p·(1024−p)/(5·1024²−4·p·(1024−p)). Here p=2·k+1 and k is `phase[30:22]`, and the result is negated when `phase[31]` is 1. Cosine is the sine of phase+2^30. On a strobe, `fund_out` becomes (amp·sin)>>>15, where amp and phase are the values held before that strobe, and it appears one clock after the strobe.
- R3: The error is e = u − fund, with products ps=(e·sin)>>>15 and pc=(e·cos)>>>15. Each product goes into its own 100-deep window that reset fills with zeros. The window mean is (window sum including the current product)·10486>>>20.
- R4: An amplitude accumulator with 16 fraction bits adds 852·(mean of ps) on each strobe. It is clamped to [0, 32767·2^16], and `amp_out` is the accumulator >>>16, so it never goes negative.
- R5: A deviation accumulator with 16 fraction bits adds 82028·(mean of pc) and is clamped to [(17179869−21474836)·2^16, (25769803−21474836)·2^16]. `freq_inc_out` is 21474836 + (deviation>>>16) + 542·(mean of pc), clamped to [17179869, 25769803], which is 40 Hz to 60 Hz.
- R6: On each strobe, `phase_out` advances by the new `freq_inc_out` and wraps modulo 2^32.
- R7: A clock edge with `sample_valid` low changes no output.
- R8: For a clean 1.0 p.u. (16384) input at 50 Hz, after 4000 samples `amp_out` lies within 5% of 16384 and `freq_inc_out` lies within 1% of 21474836.
- R9: For 1.0 p.u. at 50 Hz plus a 0.1 p.u. third and a 0.05 p.u. fifth harmonic, the peak-to-peak swing of `amp_out` over 1000 samples after settling stays at or below 820.
- R10: After the input moves to 55 Hz, and 4000 samples later, `freq_inc_out` lies within 1% of 23622320.
- R11: With a 62 Hz input, `freq_inc_out` reaches its upper clamp 25769803 and never goes above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Strobe: one new input sample this cycle |
| sample_in | input | 16 | Signed sample, 16384 = 1.0 p.u. |
| fund_out | output | 16 | Signed rebuilt fundamental A·sin θ |
| amp_out | output | 16 | Amplitude estimate, 16384 = 1.0 p.u. |
| freq_inc_out | output | 32 | Phase increment per sample (frequency estimate) |
| phase_out | output | 32 | Phase estimate, 2^32 per turn |

## Verification
The loop math is combinational within one sample, so every result of a strobe shows up exactly one clock after it. A strobe-free edge must leave every output unchanged. The bench drives inputs just after the falling edge and compares all four outputs there against an integer model that it advances only when it sends a strobe. The register between model and design therefore lines up by construction, and idle cycles are checked as holds. The settling checks for lock, harmonic ripple, frequency tracking and clamping read the outputs only after a fixed count of samples has passed.

// File: rtl/epll_mwf_pkg.sv
// Shared types and constant helpers for the windowed enhanced PLL.
// Assumes a 16-bit sine scale (32767 full scale) and 64-bit elaboration math.
package epll_mwf_pkg;

    typedef logic signed [47:0] wide_t;

    // Quarter-wave sine entry idx; the half-wave position p = 2*idx+1 with pi = 2^(bits+2).
    function automatic logic signed [15:0] quarter_sine(input int idx, input int bits);
        longint pi_u;
        longint p;
        longint q;
        longint num;
        longint den;
        pi_u = longint'(1) << (bits + 2);
        p    = 2 * longint'(idx) + 1;
        q    = p * (pi_u - p);
        num  = longint'(32767) * 16 * q;
        den  = 5 * pi_u * pi_u - 4 * q;
        return 16'(num / den);
    endfunction

    // Saturate v into [lo, hi].
    function automatic wide_t clamp_w(input wide_t v, input wide_t lo, input wide_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/epll_mwf_trig.sv
// Sine and cosine lookup from the top phase bits.
// Keeps a quarter-wave table and folds by quadrant; cosine is sine one quadrant ahead.
// Assumes the caller passes the top LUT_BITS+2 bits of the phase.
module epll_mwf_trig
    import epll_mwf_pkg::*;
#(
    parameter int LUT_BITS = 8
) (
    input  logic [LUT_BITS+1:0] phase_top,
    output logic signed [15:0]  sin_o,
    output logic signed [15:0]  cos_o
);
    localparam int LUT_N = 1 << LUT_BITS;

    logic signed [15:0] rom [LUT_N];

    for (genvar i = 0; i < LUT_N; i++) begin : g_rom
        localparam logic signed [15:0] ENTRY = quarter_sine(i, LUT_BITS);
        assign rom[i] = ENTRY;
    end

    // Channel 0 is sine, channel 1 is cosine (quadrant + 1).
    for (genvar k = 0; k < 2; k++) begin : g_ch
        logic [1:0]          quad;
        logic [LUT_BITS-1:0] addr;
        logic signed [15:0]  mag;
        logic signed [15:0]  res;
        // Fold the phase into the quarter table and restore the sign.
        always_comb begin
            quad = phase_top[LUT_BITS+1 -: 2] + 2'(k);
            addr = quad[0] ? ~phase_top[LUT_BITS-1:0] : phase_top[LUT_BITS-1:0];
            mag  = rom[addr];
            res  = quad[1] ? -mag : mag;
        end
    end

    assign sin_o = g_ch[0].res;
    assign cos_o = g_ch[1].res;

endmodule

// File: rtl/epll_mwf_winavg.sv
// Running-sum window mean over WIN_N samples (zero-bin sliding DFT).
// The mean includes the current sample combinationally; state moves on en.
// Assumes the window is zero-filled by reset and WIN_N >= 2.
module epll_mwf_winavg #(
    parameter int IN_W     = 19,
    parameter int WIN_N    = 100,
    parameter int RECIP_SH = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic signed [IN_W-1:0] x,
    output logic signed [IN_W+1:0] avg
);
    localparam int     PTR_W   = $clog2(WIN_N);
    localparam int     SUM_W   = IN_W + PTR_W + 1;
    localparam longint RECIP   = ((longint'(1) << RECIP_SH) + WIN_N / 2) / WIN_N;
    localparam int     PROD_W  = SUM_W + RECIP_SH + 2;

    logic signed [IN_W-1:0]  hist [WIN_N];
    logic [PTR_W-1:0]        ptr;
    logic signed [SUM_W-1:0] sum_q;
    logic signed [SUM_W-1:0] sum_d;

    // Multiply by the reciprocal of the window length and drop the fraction.
    function automatic logic signed [IN_W+1:0] scale_mean(input logic signed [SUM_W-1:0] s);
        logic signed [PROD_W-1:0] prod;
        prod = PROD_W'(s) * PROD_W'(RECIP);
        return (IN_W + 2)'(prod >>> RECIP_SH);
    endfunction

    // New window sum: add the incoming sample, drop the oldest.
    always_comb begin
        sum_d = sum_q + SUM_W'(x) - SUM_W'(hist[ptr]);
        avg   = scale_mean(sum_d);
    end

    // Store the sample over the oldest slot and advance the ring pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            ptr   <= '0;
            for (int i = 0; i < WIN_N; i++) hist[i] <= '0;
        end else if (en) begin
            hist[ptr] <= x;
            sum_q     <= sum_d;
            ptr       <= (ptr == PTR_W'(WIN_N - 1)) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/epll_mwf.sv
// Single-phase enhanced PLL with a window-mean filter in each loop.
// One input strobe updates amplitude, frequency deviation and phase in one cycle;
// all outputs are registered. Assumes the input is already band-limited and
// 16384 represents 1.0 p.u.
module epll_mwf
    import epll_mwf_pkg::*;
#(
    parameter int IN_W      = 16,
    parameter int ONE_SH    = 14,
    parameter int PHASE_W   = 32,
    parameter int LUT_BITS  = 8,
    parameter int FS_HZ     = 10000,
    parameter int F_NOM_HZ  = 50,
    parameter int F_MIN_HZ  = 40,
    parameter int F_MAX_HZ  = 60,
    parameter int RIPPLE_HZ = 100,
    parameter int KA        = 130,
    parameter int KP        = 130,
    parameter int KI        = 3000,
    parameter int AMP_FRAC  = 16,
    parameter int INT_FRAC  = 16,
    parameter int RECIP_SH  = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sample_valid,
    input  logic signed [IN_W-1:0] sample_in,
    output logic signed [IN_W-1:0] fund_out,
    output logic [IN_W-1:0]        amp_out,
    output logic [PHASE_W-1:0]     freq_inc_out,
    output logic [PHASE_W-1:0]     phase_out
);
    localparam int    WIN_N   = FS_HZ / RIPPLE_HZ;
    localparam int    P_W     = IN_W + 3;
    localparam int    TRIG_SH = 15;
    localparam real   TWO_PI  = 6.283185307179586;
    localparam wide_t INC_NOM = wide_t'((longint'(F_NOM_HZ) << PHASE_W) / FS_HZ);
    localparam wide_t INC_MIN = wide_t'((longint'(F_MIN_HZ) << PHASE_W) / FS_HZ);
    localparam wide_t INC_MAX = wide_t'((longint'(F_MAX_HZ) << PHASE_W) / FS_HZ);
    localparam wide_t KA_STEP = wide_t'(((longint'(KA) << AMP_FRAC) + FS_HZ / 2) / FS_HZ);
    localparam wide_t KP_STEP = wide_t'($rtoi(real'(KP) * (2.0 ** (PHASE_W - ONE_SH))
                                              / (TWO_PI * real'(FS_HZ)) + 0.5));
    localparam wide_t KI_STEP = wide_t'($rtoi(real'(KI) * (2.0 ** (PHASE_W - ONE_SH + INT_FRAC))
                                              / (TWO_PI * real'(FS_HZ) * real'(FS_HZ)) + 0.5));
    localparam wide_t AMP_HI  = wide_t'(((longint'(1) << (IN_W - 1)) - 1) << AMP_FRAC);
    localparam wide_t DEV_LO  = (INC_MIN - INC_NOM) <<< INT_FRAC;
    localparam wide_t DEV_HI  = (INC_MAX - INC_NOM) <<< INT_FRAC;

    logic [PHASE_W-1:0]     phase_q;
    logic [PHASE_W-1:0]     inc_q;
    wide_t                  amp_acc_q;
    wide_t                  dev_q;
    logic signed [IN_W-1:0] fund_q;

    logic signed [15:0]     sin_v;
    logic signed [15:0]     cos_v;
    logic signed [P_W-1:0]  prod_in [2];
    logic signed [P_W+1:0]  mean_out [2];

    wide_t                  y_w;
    wide_t                  e_w;
    wide_t                  amp_d;
    wide_t                  dev_d;
    wide_t                  inc_w;

    function automatic logic signed [P_W-1:0] to_prod(input wide_t v);
        return P_W'(v);
    endfunction

    function automatic logic signed [IN_W-1:0] to_sample(input wide_t v);
        return IN_W'(v);
    endfunction

    function automatic logic [PHASE_W-1:0] to_phase(input wide_t v);
        return PHASE_W'(v);
    endfunction

    epll_mwf_trig #(.LUT_BITS(LUT_BITS)) u_trig (
        .phase_top (phase_q[PHASE_W-1 -: LUT_BITS+2]),
        .sin_o     (sin_v),
        .cos_o     (cos_v)
    );

    // Loop 0 filters the amplitude product, loop 1 the frequency product.
    for (genvar k = 0; k < 2; k++) begin : g_loop
        epll_mwf_winavg #(
            .IN_W     (P_W),
            .WIN_N    (WIN_N),
            .RECIP_SH (RECIP_SH)
        ) u_avg (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (sample_valid),
            .x     (prod_in[k]),
            .avg   (mean_out[k])
        );
    end

    // Rebuild the fundamental, form the error and the two loop products.
    always_comb begin
        y_w        = (wide_t'(amp_acc_q >>> AMP_FRAC) * wide_t'(sin_v)) >>> TRIG_SH;
        e_w        = wide_t'(sample_in) - y_w;
        prod_in[0] = to_prod((e_w * wide_t'(sin_v)) >>> TRIG_SH);
        prod_in[1] = to_prod((e_w * wide_t'(cos_v)) >>> TRIG_SH);
    end

    // Integrate the filtered products and form the clamped phase step.
    always_comb begin
        amp_d = clamp_w(amp_acc_q + KA_STEP * wide_t'(mean_out[0]), '0, AMP_HI);
        dev_d = clamp_w(dev_q + KI_STEP * wide_t'(mean_out[1]), DEV_LO, DEV_HI);
        inc_w = clamp_w(INC_NOM + (dev_d >>> INT_FRAC) + KP_STEP * wide_t'(mean_out[1]),
                        INC_MIN, INC_MAX);
    end

    // Commit all loop state on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= '0;
            inc_q     <= to_phase(INC_NOM);
            amp_acc_q <= '0;
            dev_q     <= '0;
            fund_q    <= '0;
        end else if (sample_valid) begin
            phase_q   <= phase_q + to_phase(inc_w);
            inc_q     <= to_phase(inc_w);
            amp_acc_q <= amp_d;
            dev_q     <= dev_d;
            fund_q    <= to_sample(y_w);
        end
    end

    assign fund_out     = fund_q;
    assign amp_out      = amp_acc_q[AMP_FRAC +: IN_W];
    assign freq_inc_out = inc_q;
    assign phase_out    = phase_q;

endmodule

// File: rtl/epll_mwf_checker.sv
// Temporal checks on the PLL ports; attached to every epll_mwf instance by bind.
// Assumes the same frequency parameters as the instance it watches.
module epll_mwf_checker #(
    parameter int IN_W     = 16,
    parameter int PHASE_W  = 32,
    parameter int FS_HZ    = 10000,
    parameter int F_MIN_HZ = 40,
    parameter int F_MAX_HZ = 60
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sample_valid,
    input logic signed [IN_W-1:0] fund_out,
    input logic [IN_W-1:0]        amp_out,
    input logic [PHASE_W-1:0]     freq_inc_out,
    input logic [PHASE_W-1:0]     phase_out
);
    localparam longint INC_MIN = (longint'(F_MIN_HZ) << PHASE_W) / FS_HZ;
    localparam longint INC_MAX = (longint'(F_MAX_HZ) << PHASE_W) / FS_HZ;

    // R1: reset drives the documented idle state.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (phase_out == '0 && amp_out == '0 && fund_out == '0));

    // R2: the rebuilt wave never exceeds the amplitude it was built from.
    assert_fund_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> ($signed(fund_out) <= $signed({1'b0, $past(amp_out)}))
                      && ($signed({fund_out[IN_W-1], fund_out}) + $signed({1'b0, $past(amp_out)}) >= 0));

    // R4: amplitude estimate stays non-negative.
    assert_amp_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_out[IN_W-1]);

    // R5 / R11: frequency estimate stays within its clamp.
    assert_freq_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        longint'(freq_inc_out) >= INC_MIN && longint'(freq_inc_out) <= INC_MAX);

    // R6: a strobe advances the phase by the step it publishes.
    assert_phase_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> phase_out == $past(phase_out) + freq_inc_out);

    // R7: no strobe, no change.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(phase_out) && $stable(amp_out)
                       && $stable(freq_inc_out) && $stable(fund_out));

endmodule

bind epll_mwf epll_mwf_checker #(
    .IN_W     (IN_W),
    .PHASE_W  (PHASE_W),
    .FS_HZ    (FS_HZ),
    .F_MIN_HZ (F_MIN_HZ),
    .F_MAX_HZ (F_MAX_HZ)
) u_epll_mwf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .fund_out     (fund_out),
    .amp_out      (amp_out),
    .freq_inc_out (freq_inc_out),
    .phase_out    (phase_out)
);

// File: tb/epll_mwf_test.sv
// Bench for epll_mwf: an integer reference model advanced per strobe and
// compared on every clock, plus settling checks on lock, ripple and tracking.
module epll_mwf_test;

    localparam longint NOM   = 21474836;
    localparam longint FMIN  = 17179869;
    localparam longint FMAX  = 25769803;
    localparam longint F55   = 23622320;
    localparam longint DLO   = (FMIN - NOM) * 65536;
    localparam longint DHI   = (FMAX - NOM) * 65536;
    localparam longint AHI   = longint'(32767) * 65536;
    localparam real    PI2   = 6.283185307179586;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sample_valid = 1'b0;
    logic signed [15:0] sample_in = '0;
    logic signed [15:0] fund_out;
    logic [15:0]        amp_out;
    logic [31:0]        freq_inc_out;
    logic [31:0]        phase_out;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  last_idle = 1'b0;

    // reference model state
    longint m_acc, m_dev, m_inc, m_ph, m_y, sum_a, sum_c;
    longint qa[$];
    longint qc[$];
    real    in_ph = 0.0;

    epll_mwf uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_in    (sample_in),
        .fund_out     (fund_out),
        .amp_out      (amp_out),
        .freq_inc_out (freq_inc_out),
        .phase_out    (phase_out)
    );

    always #10ns clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint sin_ref(input longint ph);
        longint pos, p, q, v;
        pos = (ph >> 22) & 511;
        p   = 2 * pos + 1;
        q   = p * (1024 - p);
        v   = (longint'(32767) * 16 * q) / (5 * 1024 * 1024 - 4 * q);
        return ((ph >> 31) & 1) != 0 ? -v : v;
    endfunction

    function automatic longint lim(input longint v, input longint lo, input longint hi);
        return v < lo ? lo : (v > hi ? hi : v);
    endfunction

    task automatic model_reset();
        m_acc = 0; m_dev = 0; m_inc = NOM; m_ph = 0; m_y = 0;
        sum_a = 0; sum_c = 0;
        qa.delete(); qc.delete();
        for (int i = 0; i < 100; i++) begin
            qa.push_back(0);
            qc.push_back(0);
        end
    endtask

    // One strobe of the reference behaviour (R2..R6).
    task automatic model_step(input longint u);
        longint s, c, e, ps, pc, fa, fc;
        s  = sin_ref(m_ph);
        c  = sin_ref((m_ph + (longint'(1) << 30)) & 64'hFFFF_FFFF);
        m_y = ((m_acc >>> 16) * s) >>> 15;
        e  = u - m_y;
        ps = (e * s) >>> 15;
        pc = (e * c) >>> 15;
        qa.push_back(ps);
        qc.push_back(pc);
        sum_a = sum_a + ps - qa.pop_front();
        sum_c = sum_c + pc - qc.pop_front();
        fa = (sum_a * 10486) >>> 20;
        fc = (sum_c * 10486) >>> 20;
        m_acc = lim(m_acc + 852 * fa, 0, AHI);
        m_dev = lim(m_dev + 82028 * fc, DLO, DHI);
        m_inc = lim(NOM + (m_dev >>> 16) + 542 * fc, FMIN, FMAX);
        m_ph  = (m_ph + m_inc) & 64'hFFFF_FFFF;
    endtask

    // Compare every output with the model; idle edges are tagged R7.
    task automatic compare_all();
        check(longint'(fund_out) == m_y, last_idle ? "R7" : "R2", "fund_out",
              longint'(fund_out), m_y);
        check(longint'(amp_out) == (m_acc >>> 16), last_idle ? "R7" : "R4(R3)", "amp_out",
              longint'(amp_out), m_acc >>> 16);
        check(longint'(freq_inc_out) == m_inc, last_idle ? "R7" : "R5", "freq_inc_out",
              longint'(freq_inc_out), m_inc);
        check(longint'(phase_out) == m_ph, last_idle ? "R7" : "R6", "phase_out",
              longint'(phase_out), m_ph);
    endtask

    task automatic tick(input bit valid, input longint u);
        @(negedge clk);
        compare_all();
        last_idle    = !valid;
        sample_valid = valid;
        sample_in    = 16'(u);
        if (valid) model_step(u);
    endtask

    // n samples at frequency f; optional idle cycle after each sample.
    task automatic run(input int n, input real f, input real a1, input real a3,
                       input real a5, input bit gaps);
        for (int i = 0; i < n; i++) begin
            real v;
            v = a1 * $sin(in_ph) + a3 * $sin(3.0 * in_ph) + a5 * $sin(5.0 * in_ph);
            tick(1'b1, longint'($rtoi(16384.0 * v + (v >= 0.0 ? 0.5 : -0.5))));
            if (gaps) tick(1'b0, 0);
            in_ph = in_ph + PI2 * f / 10000.0;
            if (in_ph > PI2) in_ph = in_ph - PI2;
        end
    endtask

    initial begin : watchdog
        #4ms;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        longint amin, amax, fmax_seen;
        logic [15:0] h_amp;
        logic [31:0] h_ph;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(fund_out == 16'sd0, "R1", "fund_out", longint'(fund_out), 0);
        check(amp_out == 16'd0, "R1", "amp_out", longint'(amp_out), 0);
        check(phase_out == 32'd0, "R1", "phase_out", longint'(phase_out), 0);
        check(longint'(freq_inc_out) == NOM, "R1", "freq_inc_out", longint'(freq_inc_out), NOM);
        rst_n = 1'b1;

        // R8: clean 50 Hz lock
        run(4000, 50.0, 1.0, 0.0, 0.0, 1'b0);
        tick(1'b0, 0);
        check(longint'(amp_out) >= 15564 && longint'(amp_out) <= 17204, "R8", "amp lock",
              longint'(amp_out), 16384);
        check(longint'(freq_inc_out) >= NOM - 214748 && longint'(freq_inc_out) <= NOM + 214748,
              "R8", "freq lock", longint'(freq_inc_out), NOM);

        // R7: explicit hold over idle cycles
        h_amp = amp_out;
        h_ph  = phase_out;
        repeat (10) tick(1'b0, 0);
        check(amp_out == h_amp, "R7", "amp hold", longint'(amp_out), longint'(h_amp));
        check(phase_out == h_ph, "R7", "phase hold", longint'(phase_out), longint'(h_ph));

        // amplitude step and 40 degree phase jump, strobes with gaps
        in_ph = in_ph + PI2 * 40.0 / 360.0;
        run(1500, 50.0, 0.7, 0.0, 0.0, 1'b1);
        run(1500, 50.0, 1.0, 0.0, 0.0, 1'b0);

        // R9: harmonic content
        run(2000, 50.0, 1.0, 0.1, 0.05, 1'b0);
        amin = 65535; amax = 0;
        for (int i = 0; i < 1000; i++) begin
            run(1, 50.0, 1.0, 0.1, 0.05, 1'b0);
            if (longint'(amp_out) < amin) amin = longint'(amp_out);
            if (longint'(amp_out) > amax) amax = longint'(amp_out);
        end
        check(amax - amin <= 820, "R9", "amp ripple p2p", amax - amin, 820);

        // R10: frequency step to 55 Hz
        run(4000, 55.0, 1.0, 0.0, 0.0, 1'b0);
        tick(1'b0, 0);
        check(longint'(freq_inc_out) >= F55 - 236223 && longint'(freq_inc_out) <= F55 + 236223,
              "R10", "freq track", longint'(freq_inc_out), F55);

        // R11: input beyond the clamp
        fmax_seen = 0;
        for (int i = 0; i < 3000; i++) begin
            run(1, 62.0, 1.0, 0.0, 0.0, 1'b0);
            if (longint'(freq_inc_out) > fmax_seen) fmax_seen = longint'(freq_inc_out);
        end
        check(fmax_seen == FMAX, "R11", "upper clamp reached", fmax_seen, FMAX);

        tick(1'b0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule